// File: doc/BRIEF.md
# Ternary Content-Addressable Memory with Sequenced Write

This block is a 32-entry, 32-bit ternary content-addressable memory. A key given on the search port is compared with every valid stored word in the same clock. The result is registered and appears on the next cycle. The block has two result modes, chosen per search by a mode input. In encoded mode it gives a hit flag and the address of the lowest-numbered matching entry. In banked one-hot mode it gives sixteen lines, one per word, taken from either the lower or the upper half of the array.

Entries are loaded through a write port using a short sequence. The write enable is held for two cycles with the address and data, and the entry is committed at the end of the second cycle. If the enable stays high for a third cycle, the data on that cycle is compared with the first-cycle data, and every bit that differs becomes a don't-care bit of the entry. Reset and a synchronous clear input mark every entry invalid, so the block always starts empty.

Top module: `tern_cam`

## Requirements
- R1: After reset the block holds no valid entry, and every search misses in both modes; all registered outputs are zero during reset.
- R2: A write that holds wr_en high for two consecutive cycles, starting from idle, stores the first-cycle data at the first-cycle address at the end of the second cycle, marks the entry valid, and makes all 32 bits take part in comparison.
- R3: If wr_en stays high for a third consecutive cycle, every bit position where wr_data on that cycle differs from the first-cycle data becomes don't-care for that entry.
- R4: Don't-care bits are ignored in comparison: an entry stored as 0xD4 with bit 3 masked matches keys 0xD4 and 0xDC, but not 0xC4.
- R5: In encoded mode (unenc = 0), a search with srch_en high gives res_valid = 1 on the next cycle. It also gives hit = 1 and hit_addr equal to a matching entry's index when some valid entry matches, and hit = 0 with hit_addr = 0 when none does.
- R6: When several entries match in encoded mode, hit_addr is the lowest matching index.
- R7: In banked mode (unenc = 1), key bit 31 is the bank select and only bits 30..0 are compared. With select = 1, line i shows entry i for i = 0..15. With select = 0, line i shows entry 16 + i. In this mode hit and hit_addr are 0.
- R8: The lines are 0 after an encoded search. The cycle after srch_en is low, res_valid, hit, hit_addr and the lines are all 0.
- R9: A write whose enable is high for only one cycle leaves the target entry unchanged.
- R10: A search in the same cycle as a commit compares against the contents from before that commit.
- R11: clr invalidates every entry at the next edge and cancels a write sequence in progress, including a commit that falls in the same cycle.
- R12: Holding wr_en beyond the third cycle has no further effect. A new sequence starts only after wr_en has been low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous invalidate of all entries |
| wr_en | input | 1 | Write sequence enable |
| wr_addr | input | 5 | Entry index to write |
| wr_data | input | 32 | Write data; on the third cycle, the don't-care positions are inverted |
| srch_en | input | 1 | Search request |
| unenc | input | 1 | Result mode: 0 encoded, 1 banked one-hot |
| key | input | 32 | Search key; bit 31 is the bank select in banked mode |
| res_valid | output | 1 | Result present (one cycle after srch_en) |
| hit | output | 1 | Encoded-mode match flag |
| hit_addr | output | 5 | Encoded-mode lowest matching index |
| bank_lines | output | 16 | Banked-mode per-entry match lines |

## Verification
The assertions watch on every cycle that the sequencer only commits after an enable that was already high, and that a mask update only reaches an entry that has just become valid. They also check that clear empties the array by the next edge, that the outputs of the unused mode stay zero, and that an encoded address always points to the lowest match. The bench's scenarios are needed for the rest: the exact stored words and masks, results that depend on the data, a search overlapping a commit, interrupted and over-long write sequences, and a clear that collides with a commit. Those scenarios compare every result against a model of the array kept in the bench.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ARMED = 2'd1,
    WS_MASK  = 2'd2,
    WS_HOLD  = 2'd3
  } wseq_state_e;

  localparam int unsigned RESULT_BANKS = 2;
endpackage

// File: rtl/tcam_wr_seq.sv
module tcam_wr_seq
  import tcam_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned W  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic          base_we,
  output logic          care_we,
  output logic [AW-1:0] cmt_addr,
  output logic [W-1:0]  cmt_data,
  output logic [W-1:0]  cmt_care
);
  wseq_state_e   state;
  logic [AW-1:0] cap_addr;
  logic [W-1:0]  cap_data;

  // Commit strobes are combinational so the array updates on the edge
  // that closes the second (or third) cycle.
  always_comb begin
    base_we  = (state == WS_ARMED) && wr_en && !clr;
    care_we  = (state == WS_MASK) && wr_en && !clr;
    cmt_addr = cap_addr;
    cmt_data = cap_data;
    cmt_care = care_we ? ~(cap_data ^ wr_data) : '1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state <= WS_IDLE;
    end else begin
      unique case (state)
        WS_IDLE:  if (wr_en) state <= WS_ARMED;
        WS_ARMED: state <= wr_en ? WS_MASK : WS_IDLE;
        WS_MASK:  state <= wr_en ? WS_HOLD : WS_IDLE;
        WS_HOLD:  if (!wr_en) state <= WS_IDLE;
        default:  state <= WS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == WS_IDLE && wr_en) begin
      cap_addr <= wr_addr;
      cap_data <= wr_data;
    end
  end

  AST_BASE_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    base_we |-> $past(wr_en)); // R2
  AST_CARE_AFTER_BASE: assert property (@(posedge clk) disable iff (rst)
    care_we |-> $past(base_we)); // R3
endmodule

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int unsigned N  = 32,
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          base_we,
  input  logic          care_we,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  wr_care,
  input  logic [W-1:0]  key,
  input  logic [W-1:0]  cmp_mask,
  output logic [N-1:0]  match
);
  logic [W-1:0] val_q  [N];
  logic [W-1:0] care_q [N];
  logic [N-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q <= '0;
    end else if (base_we) begin
      vld_q[wr_addr] <= 1'b1;
    end
  end

  // Word storage carries no reset; only the valid bits do.
  always_ff @(posedge clk) begin
    if (base_we) begin
      val_q[wr_addr]  <= wr_data;
      care_q[wr_addr] <= '1;
    end else if (care_we) begin
      care_q[wr_addr] <= wr_care;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    always_comb
      match[g] = vld_q[g] && (((key ^ val_q[g]) & care_q[g] & cmp_mask) == '0);
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (vld_q == '0)); // R11
  AST_CARE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    care_we |-> vld_q[wr_addr]); // R3
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [AW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = AW'(i);
    end
  end
endmodule

// File: rtl/tern_cam.sv
module tern_cam
  import tcam_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned WIDTH   = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [$clog2(ENTRIES)-1:0]   wr_addr,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic                         srch_en,
  input  logic                         unenc,
  input  logic [WIDTH-1:0]             key,
  output logic                         res_valid,
  output logic                         hit,
  output logic [$clog2(ENTRIES)-1:0]   hit_addr,
  output logic [ENTRIES/RESULT_BANKS-1:0] bank_lines
);
  localparam int unsigned AW    = $clog2(ENTRIES);
  localparam int unsigned LINES = ENTRIES / RESULT_BANKS;

  logic          base_we, care_we;
  logic [AW-1:0] cmt_addr;
  logic [WIDTH-1:0] cmt_data, cmt_care, cmp_mask;
  logic [ENTRIES-1:0] match;
  logic          enc_any;
  logic [AW-1:0] enc_idx;
  logic [LINES-1:0] lines_nxt;
  logic [ENTRIES-1:0] low_mask;

  tcam_wr_seq #(.AW(AW), .W(WIDTH)) u_seq (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base_we(base_we), .care_we(care_we),
    .cmt_addr(cmt_addr), .cmt_data(cmt_data), .cmt_care(cmt_care)
  );

  // In banked mode the top key bit selects the bank and is not compared.
  always_comb cmp_mask = unenc ? {1'b0, {(WIDTH-1){1'b1}}} : '1;

  tcam_store #(.N(ENTRIES), .W(WIDTH), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .clr(clr),
    .base_we(base_we), .care_we(care_we),
    .wr_addr(cmt_addr), .wr_data(cmt_data), .wr_care(cmt_care),
    .key(key), .cmp_mask(cmp_mask), .match(match)
  );

  tcam_prio_enc #(.N(ENTRIES), .AW(AW)) u_enc (
    .vec(match), .any(enc_any), .idx(enc_idx)
  );

  always_comb lines_nxt = key[WIDTH-1] ? match[LINES-1:0] : match[ENTRIES-1:LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      hit        <= 1'b0;
      hit_addr   <= '0;
      bank_lines <= '0;
    end else begin
      res_valid  <= srch_en;
      hit        <= srch_en && !unenc && enc_any;
      hit_addr   <= (srch_en && !unenc && enc_any) ? enc_idx : '0;
      bank_lines <= (srch_en && unenc) ? lines_nxt : '0;
    end
  end

  always_comb low_mask = (ENTRIES'(1) << hit_addr) - ENTRIES'(1);

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    hit |-> res_valid); // R5
  AST_UNENC_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (srch_en && unenc) |=> (!hit && hit_addr == '0)); // R7
  AST_ENC_NO_LINES: assert property (@(posedge clk) disable iff (rst)
    (srch_en && !unenc) |=> (bank_lines == '0)); // R8
  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (srch_en && !unenc && match != '0) |=>
      (hit && (($past(match) & low_mask) == '0) &&
       ((($past(match) >> hit_addr) & ENTRIES'(1)) != '0))); // R6
endmodule

// File: tb/tern_cam_bench.sv
module tern_cam_bench;
  logic        clk = 1'b0;
  logic        rst, clr, wr_en, srch_en, unenc;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data, key;
  logic        res_valid, hit;
  logic [4:0]  hit_addr;
  logic [15:0] bank_lines;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] m_val  [32];
  logic [31:0] m_care [32];
  logic [31:0] m_vld;

  always #10 clk = ~clk;

  tern_cam u_tern_cam (
    .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .srch_en(srch_en), .unenc(unenc), .key(key),
    .res_valid(res_valid), .hit(hit), .hit_addr(hit_addr), .bank_lines(bank_lines)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] model_match(input logic [31:0] k, input logic u);
    logic [31:0] cm = u ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
    logic [31:0] mv = '0;
    for (int i = 0; i < 32; i++)
      mv[i] = m_vld[i] && (((k ^ m_val[i]) & m_care[i] & cm) == 32'h0);
    return mv;
  endfunction

  task automatic expect_result(input string req, input logic [31:0] k, input logic u);
    logic [31:0] mv = model_match(k, u);
    logic eh = 1'b0;
    logic [4:0] ea = '0;
    logic [15:0] el = '0;
    if (!u) begin
      for (int i = 31; i >= 0; i--) if (mv[i]) begin eh = 1'b1; ea = 5'(i); end
    end else begin
      el = k[31] ? mv[15:0] : mv[31:16];
    end
    chk(req, {38'h0, res_valid, hit, hit_addr, bank_lines}, {38'h0, 1'b1, eh, ea, el});
  endtask

  task automatic search(input string req, input logic [31:0] k, input logic u);
    @(negedge clk);
    srch_en = 1'b1; key = k; unenc = u;
    @(posedge clk);
    @(negedge clk);
    srch_en = 1'b0;
    expect_result(req, k, u);
  endtask

  // ncyc: number of cycles wr_en is held; data for cycle 3 and beyond is d3/d4.
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input int ncyc,
                    input logic [31:0] d3, input logic [31:0] d4);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    for (int c = 1; c <= ncyc; c++) begin
      if (c == 3) wr_data = d3;
      if (c >= 4) wr_data = d4;
      @(posedge clk);
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(posedge clk);
    if (ncyc >= 2) begin
      m_val[a] = d; m_care[a] = 32'hFFFF_FFFF; m_vld[a] = 1'b1;
      if (ncyc >= 3) m_care[a] = ~(d ^ d3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clr = 1'b0; wr_en = 1'b0; srch_en = 1'b0; unenc = 1'b0;
    wr_addr = '0; wr_data = '0; key = '0; m_vld = '0;
    for (int i = 0; i < 32; i++) begin m_val[i] = '0; m_care[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {38'h0, res_valid, hit, hit_addr, bank_lines}, 64'h0);
    rst = 1'b0;
    search("R1 empty enc", 32'h0, 1'b0);
    search("R1 empty bank1", 32'h8000_0000, 1'b1);
    search("R1 empty bank0", 32'h0, 1'b1);

    for (int i = 0; i < 32; i++) wr(5'(i), pat(i), 2, '0, '0);
    for (int i = 0; i < 32; i++) begin
      search("R2 R5 enc sweep", pat(i), 1'b0);
      search("R7 bank sel1 sweep", {1'b1, pat(i)[30:0]}, 1'b1);
      search("R7 bank sel0 sweep", {1'b0, pat(i)[30:0]}, 1'b1);
      search("R5 miss sweep", ~pat(i), 1'b0);
    end

    @(negedge clk);
    chk("R8 idle outputs", {38'h0, res_valid, hit, hit_addr, bank_lines}, 64'h0);

    wr(5'd20, pat(3), 2, '0, '0);
    search("R6 duplicate lowest", pat(3), 1'b0);
    search("R7 duplicate bank1", {1'b1, pat(3)[30:0]}, 1'b1);
    search("R7 duplicate bank0", {1'b0, pat(3)[30:0]}, 1'b1);

    wr(5'd9, 32'h0000_00D4, 3, 32'h0000_00DC, '0);
    search("R4 masked key D4", 32'h0000_00D4, 1'b0);
    search("R4 masked key DC", 32'h0000_00DC, 1'b0);
    search("R4 unmasked C4 miss", 32'h0000_00C4, 1'b0);
    chk("R3 mask model", {32'h0, m_care[9]}, {32'h0, 32'hFFFF_FFF7});

    wr(5'd4, 32'h1234_5678, 1, '0, '0);
    search("R9 interrupted old kept", pat(4), 1'b0);
    search("R9 interrupted new absent", 32'h1234_5678, 1'b0);

    wr(5'd7, 32'h0F0F_0000, 4, 32'h0F0F_00FF, 32'hFFFF_FFFF);
    search("R12 hold mask low byte", 32'h0F0F_00A5, 1'b0);
    search("R12 fourth cycle no effect", 32'hF0F0_0000, 1'b0);

    // Search in the commit cycle of a write to entry 11
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd11; wr_data = 32'hCAFE_0011;
    @(posedge clk);
    @(negedge clk);
    srch_en = 1'b1; key = pat(11); unenc = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; srch_en = 1'b0;
    expect_result("R10 search sees old", pat(11), 1'b0);
    m_val[11] = 32'hCAFE_0011; m_care[11] = 32'hFFFF_FFFF;
    @(posedge clk);
    search("R10 new after commit", 32'hCAFE_0011, 1'b0);
    search("R10 old gone", pat(11), 1'b0);

    wr(5'd30, 32'h0, 3, 32'hFFFF_FFFF, '0);
    search("R3 all care off enc", 32'h7777_1234, 1'b0);
    search("R3 all care off bank0", 32'h0000_4321, 1'b1);

    // Clear colliding with a commit to entry 2
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd2; wr_data = 32'hBEEF_0002;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0; wr_en = 1'b0;
    m_vld = '0;
    @(posedge clk);
    search("R11 clear commit dropped", 32'hBEEF_0002, 1'b0);
    search("R11 cleared old", pat(0), 1'b0);
    search("R11 cleared bank", 32'h8000_0000, 1'b1);
    wr(5'd2, 32'hBEEF_0002, 2, '0, '0);
    search("R11 write after clear", 32'hBEEF_0002, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule